// File: doc/BRIEF.md
# Conversion Queue Start and Pause Controller

This block decides when one command queue of a queued analog-to-digital converter begins a scan, steps from one command word to the next, and halts at pause points. Software programs a small control word holding a pause-interrupt enable, a one-shot scan arm bit and a five-bit mode code. The mode code picks the start source. The source can be a software write, a rising edge on an external trigger pin, a falling edge on that pin, or an internal interval timer. The timer counts ticks of the conversion clock and offers one of five power-of-two periods.

The converter itself, result storage and command-word memory live elsewhere. The block asks for a conversion with a one-cycle start strobe and a command index. It then waits for a done strobe that carries two flags: a pause flag and an end-of-queue flag. A pause flag halts the queue and can raise a one-cycle interrupt request. The next accepted trigger resumes the queue at the following command word. End of queue returns the block to idle and disarms the arm bit, so the next scan needs a fresh arm.

Top module: `adc_queue_trigger`

## Requirements
- R1: After reset, q_status is 0 (idle), conv_start and pause_irq are 0, and cfg_rdata is 0.
- R2: The control word is {pause-interrupt enable at bit 6, arm bit at bit 5, mode at bits 4:0}. A read returns the enable bit and the mode as last written, and bit 5 always reads 0.
- R3: Mode 0 and every mode above 8 are disabled. No conversion starts, whatever trigger arrives, and writing such a mode forces the queue to idle.
- R4: In mode 1, a control write with mode 1 and the arm bit set starts a scan. conv_start is high in the cycle after the write, with cmd_idx 0 and q_status 1 (active).
- R5: Mode 2 starts on a rising edge of ext_trig and mode 3 on a falling edge. The opposite edge is ignored. The pin passes two synchroniser flops, so conv_start rises three clock edges after the pin changes.
- R6: A hardware trigger is ignored while the arm bit is 0.
- R7: Modes 4 to 8 start a scan after 2^(mode+3) qclk_tick pulses counted from the control write, giving 128 up to 2048.
- R8: A done strobe with neither flag set raises conv_start in the next cycle with cmd_idx one higher.
- R9: A done strobe with the end-of-queue flag returns the queue to idle and clears the arm bit, so later hardware triggers start nothing.
- R10: A done strobe with the pause flag (and no end-of-queue flag) enters the paused state (q_status 2). It pulses pause_irq for exactly one cycle when the enable bit is 1, and leaves pause_irq low otherwise. The next accepted trigger resumes the queue at the next command index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 7 | Control word to write |
| cfg_rdata | output | 7 | Control word read-back (arm bit reads 0) |
| qclk_tick | input | 1 | One pulse per conversion clock period |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| conv_start | output | 1 | One-cycle request to convert command cmd_idx |
| cmd_idx | output | 6 | Current command word index |
| conv_done | input | 1 | Conversion finished strobe |
| conv_pause | input | 1 | Finished command word carried a pause mark |
| conv_eoq | input | 1 | Finished command word was the last of the queue |
| pause_irq | output | 1 | One-cycle pause interrupt request |
| q_status | output | 2 | 0 idle, 1 active, 2 paused |

## Verification
A wrong state register shows up on q_status or as a missing or extra conv_start within one cycle of the stimulus that should have moved it. A stuck arm bit only shows when a later trigger is offered after end of queue, so the bench offers one and expects no start. A wrong timer period or edge polarity shifts the first conv_start away from the expected cycle, and the scoreboard catches this on the exact cycle. A misplaced index increment appears as a wrong cmd_idx on the next start, either after a plain done or after a resume from pause.

// File: rtl/adc_queue_trigger.sv
module adc_queue_trigger #(
  parameter int MODE_W      = 5,
  parameter int TMR_MIN_EXP = 7,
  parameter int TMR_MODES   = 5,
  parameter int IDX_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [MODE_W+1:0]   cfg_wdata,
  output logic [MODE_W+1:0]   cfg_rdata,
  input  logic                qclk_tick,
  input  logic                ext_trig,
  output logic                conv_start,
  output logic [IDX_W-1:0]    cmd_idx,
  input  logic                conv_done,
  input  logic                conv_pause,
  input  logic                conv_eoq,
  output logic                pause_irq,
  output logic [1:0]          q_status
);
  localparam int TMR_FIRST = 4;
  localparam int TMR_LAST  = TMR_FIRST + TMR_MODES - 1;
  localparam int CNT_W     = TMR_MIN_EXP + TMR_MODES - 1;

  localparam logic [MODE_W-1:0] M_SW   = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_RISE = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_FALL = MODE_W'(3);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACTIVE = 2'd1, ST_PAUSED = 2'd2} qstate_e;

  qstate_e             state_q;
  logic [MODE_W-1:0]   mode_q;
  logic                arm_q, pie_q;
  logic [2:0]          sync_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    tmr_mask;
  logic [IDX_W-1:0]    idx_q;
  logic                start_q, irq_q;

  wire [MODE_W-1:0] wr_mode = cfg_wdata[MODE_W-1:0];
  wire              wr_arm  = cfg_wdata[MODE_W];
  wire              wr_pie  = cfg_wdata[MODE_W+1];

  wire mode_ok   = (mode_q != '0) && (int'(mode_q) <= TMR_LAST);
  wire wr_bad    = (wr_mode == '0) || (int'(wr_mode) > TMR_LAST);
  wire is_tmr    = (int'(mode_q) >= TMR_FIRST) && (int'(mode_q) <= TMR_LAST);
  wire pin_rise  = sync_q[1] & ~sync_q[2];
  wire pin_fall  = ~sync_q[1] & sync_q[2];

  always_comb begin
    tmr_mask = '0;
    for (int i = 0; i < CNT_W; i++)
      if (i < int'(mode_q) - TMR_FIRST + TMR_MIN_EXP) tmr_mask[i] = 1'b1;
  end

  wire tmr_hit = is_tmr && qclk_tick && ((cnt_q & tmr_mask) == tmr_mask);

  logic hw_hit;
  always_comb begin
    case (mode_q)
      M_RISE:  hw_hit = pin_rise;
      M_FALL:  hw_hit = pin_fall;
      default: hw_hit = tmr_hit;
    endcase
  end

  wire sw_hit = cfg_we && wr_arm && (wr_mode == M_SW);
  wire accept = cfg_we ? sw_hit : (arm_q && mode_ok && (mode_q != M_SW) && hw_hit);

  assign cfg_rdata  = {pie_q, 1'b0, mode_q};
  assign conv_start = start_q;
  assign cmd_idx    = idx_q;
  assign pause_irq  = irq_q;
  assign q_status   = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_trig};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (cfg_we)    cnt_q <= '0;
    else if (qclk_tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      arm_q   <= 1'b0;
      pie_q   <= 1'b0;
      idx_q   <= '0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      if (cfg_we) begin
        mode_q <= wr_mode;
        arm_q  <= wr_arm;
        pie_q  <= wr_pie;
      end
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ACTIVE;
          idx_q   <= '0;
          start_q <= 1'b1;
        end
        ST_ACTIVE: if (conv_done) begin
          irq_q <= conv_pause & pie_q;
          if (conv_eoq) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            if (!cfg_we) arm_q <= 1'b0;
          end else if (conv_pause) begin
            state_q <= ST_PAUSED;
            idx_q   <= idx_q + 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            start_q <= 1'b1;
          end
        end
        ST_PAUSED: if (accept) begin
          state_q <= ST_ACTIVE;
          start_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (cfg_we && wr_bad) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
        start_q <= 1'b0;
      end
    end
  end

  a_r8_start_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> q_status == 2'd1);

  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |-> (q_status == 2'd0 && !conv_start));

  a_r9_eoq_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (q_status == 2'd1 && conv_done && conv_eoq) |=> q_status == 2'd0);

  a_r10_irq_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    pause_irq |-> q_status != 2'd1);

  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    pause_irq |=> !pause_irq);

  a_r4_sw_start: assert property (@(posedge clk) disable iff (!rst_n)
    (q_status == 2'd0 && cfg_we && wr_arm && wr_mode == M_SW) |=> (conv_start && cmd_idx == '0));
endmodule

// File: tb/adc_queue_trigger_tb_top.sv
module adc_queue_trigger_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic [6:0] cfg_rdata;
  logic       qclk_tick = 1'b1;
  logic       ext_trig = 1'b0;
  logic       conv_start;
  logic [5:0] cmd_idx;
  logic       conv_done = 1'b0, conv_pause = 1'b0, conv_eoq = 1'b0;
  logic       pause_irq;
  logic [1:0] q_status;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  adc_queue_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .qclk_tick(qclk_tick), .ext_trig(ext_trig), .conv_start(conv_start), .cmd_idx(cmd_idx),
    .conv_done(conv_done), .conv_pause(conv_pause), .conv_eoq(conv_eoq),
    .pause_irq(pause_irq), .q_status(q_status));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit pie, input bit arm, input int mode);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {pie, arm, 5'(mode)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic done(input bit p, input bit e);
    @(negedge clk);
    conv_done = 1'b1; conv_pause = p; conv_eoq = e;
    @(negedge clk);
    conv_done = 1'b0; conv_pause = 1'b0; conv_eoq = 1'b0;
  endtask

  task automatic pin(input bit v);
    @(negedge clk);
    ext_trig = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic tmr_test(input int mode, input int period);
    wr(0, 1, mode);
    repeat (period - 1) @(negedge clk);
    chk(conv_start == 1'b0, "R7 early", int'(conv_start), 0);
    exp_q.push_back(0);
    @(negedge clk);
    chk(conv_start == 1'b1, "R7 period", int'(conv_start), 1);
    done(0, 1);
  endtask

  // scoreboard monitor: every start must match the next expected index
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected start", int'(cmd_idx), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(cmd_idx) == e, "R8 start index", int'(cmd_idx), e);
      end
    end
  end

  initial begin
    #4ms;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(q_status == 0, "R1 status", q_status, 0);
    chk(!conv_start && !pause_irq, "R1 outputs", int'(conv_start | pause_irq), 0);
    chk(cfg_rdata == 0, "R1 rdata", cfg_rdata, 0);

    // R2, R3 disabled codes
    wr(1, 1, 9);
    chk(cfg_rdata == 7'h49, "R2 readback", cfg_rdata, 'h49);
    pin(1); pin(0);
    chk(q_status == 0, "R3 mode 9", q_status, 0);
    wr(0, 1, 0);
    pin(1); pin(0);
    chk(q_status == 0, "R3 mode 0", q_status, 0);

    // R4 software start, R8 stepping, R9 end
    exp_q.push_back(0);
    wr(0, 1, 1);
    chk(conv_start == 1 && q_status == 1, "R4 sw start", q_status, 1);
    exp_q.push_back(1);
    done(0, 0);
    chk(cmd_idx == 1 && conv_start == 1, "R8 next index", cmd_idx, 1);
    done(0, 1);
    chk(q_status == 0, "R9 idle after eoq", q_status, 0);

    // R5 rising edge, R9 arm cleared
    wr(0, 1, 2);
    exp_q.push_back(0);
    pin(1);
    chk(conv_start == 1, "R5 rising start", conv_start, 1);
    pin(0);
    done(0, 1);
    pin(1);
    chk(q_status == 0, "R9 no restart", q_status, 0);
    pin(0);

    // R6 disarmed
    wr(0, 0, 2);
    pin(1);
    chk(q_status == 0, "R6 disarmed", q_status, 0);
    pin(0);

    // R5 falling edge with latency, R10 with enable
    wr(1, 1, 3);
    pin(1);
    chk(q_status == 0, "R5 rising ignored", q_status, 0);
    exp_q.push_back(0);
    @(negedge clk); ext_trig = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(conv_start == 0, "R5 latency early", conv_start, 0);
    @(negedge clk);
    chk(conv_start == 1, "R5 falling start", conv_start, 1);
    done(1, 0);
    chk(pause_irq == 1 && q_status == 2, "R10 irq and pause", pause_irq, 1);
    @(negedge clk);
    chk(pause_irq == 0, "R10 irq one cycle", pause_irq, 0);
    pin(1);
    chk(q_status == 2, "R10 wrong edge keeps pause", q_status, 2);
    exp_q.push_back(1);
    pin(0);
    chk(q_status == 1 && cmd_idx == 1, "R10 resume index", cmd_idx, 1);
    done(0, 1);

    // R10 without enable
    exp_q.push_back(0);
    wr(0, 1, 1);
    done(1, 0);
    chk(pause_irq == 0 && q_status == 2, "R10 no irq when disabled", pause_irq, 0);
    exp_q.push_back(1);
    wr(0, 1, 1);
    chk(q_status == 1 && cmd_idx == 1, "R10 sw resume", cmd_idx, 1);
    done(0, 1);

    // R7 interval timer periods
    tmr_test(4, 128);
    tmr_test(5, 256);
    tmr_test(8, 2048);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all starts seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule